// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block sits on the read path of a flash sector controller. Each sector carries a 24-bit Hamming code written at program time. After a read, the same code is recomputed from the data that came back. The block takes both codes on a start strobe and forms their XOR syndrome. It sorts the result into one of four outcomes: clean, single data bit fixed, damage confined to the stored code, or beyond repair. When a single data bit is at fault, it reports the byte and bit position.

The syndrome interleaves true and inverted parity bits. A correctable data error therefore shows as every adjacent bit pair of the syndrome holding two different values. The location is then read straight from the even-numbered syndrome bits. A syndrome with exactly one bit set cannot come from a data error, so it is classed as damage to the stored code and the data is left alone.

An optional read-modify-write port repairs the sector buffer in place. It reads the bad byte, flips the one faulty bit and writes the byte back. The buffer is expected to be dual ported with a one-cycle read latency. Parameters set the sector size, the data width, an optional syndrome register stage, and whether the repair port is built at all.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: When the stored and recomputed codes are equal, the status is 0 (clean), and both the byte index and the bit index are 0.
- R2: Take a non-zero syndrome S = stored XOR recomputed. If S[2k+1] differs from S[2k] for every k in 0..11, the status is 1 (data bit fixed).
- R3: For status 1, the bit index is {S[22], S[20], S[18]}, with the most significant bit first.
- R4: For status 1, the byte index is {S[16], S[14], S[12], S[10], S[8], S[6], S[4], S[2], S[0]}, with the most significant bit first.
- R5: A syndrome with exactly one bit set gives status 2 (stored code damaged). The location reads 0 and the buffer is neither read nor written.
- R6: Any other non-zero syndrome gives status 3 (uncorrectable). The location reads 0 and the buffer is not accessed.
- R7: The done output is high for one cycle per start, exactly 1+SYN_REG clock cycles after the start was sampled. The status and location are valid in that cycle and held until the next result.
- R8: For status 1, the read strobe is raised in the done cycle with the byte index as its address. In the next cycle, the write strobe is raised with that same address, and the write data is the returned byte with bit (bit index) inverted.
- R9: After reset, done, the read strobe and the write strobe are low, and the status is 0.
- R10: With FIX_EN=0, the buffer strobes stay low for every outcome, and the classification is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: codes below are valid, classify them |
| code_stored_i | input | CODE_W | Code read back from the spare area |
| code_calc_i | input | CODE_W | Code recomputed from the read data |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 0 clean, 1 data fixed, 2 code damaged, 3 uncorrectable |
| err_byte_o | output | $clog2(SECTOR_BYTES) | Byte index of the bad bit |
| err_bit_o | output | $clog2(DATA_W) | Bit index within that byte |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_raddr_o | output | $clog2(SECTOR_BYTES) | Buffer read address |
| buf_rdata_i | input | DATA_W | Buffer read data, one cycle after the strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_waddr_o | output | $clog2(SECTOR_BYTES) | Buffer write address |
| buf_wdata_o | output | DATA_W | Corrected byte |

## Verification
The bench builds two copies side by side on the same stimulus.

The first uses the defaults: 512-byte sectors, 8-bit data, a registered syndrome and the repair port. With it, the bench covers two-cycle latency, back-to-back starts overlapping a repair, and the extreme byte and bit indices. It also checks a full sector image against a model after every fix.

The second is built with SYN_REG=0 and FIX_EN=0. It shows that the single-cycle variant classifies identically and that the repair-free variant never touches its buffer port.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN      = 2'b00,
      ST_DATA_FIXED = 2'b01,
      ST_CODE_BAD   = 2'b10,
      ST_UNCORR     = 2'b11
   } fix_status_e;

endpackage

// File: rtl/ecc_syn_stage.sv
module ecc_syn_stage #(
   parameter int CODE_W  = 24,
   parameter bit SYN_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_a_i,
   input  logic [CODE_W-1:0] code_b_i,
   output logic              vld_o,
   output logic [CODE_W-1:0] syn_o
);

   logic [CODE_W-1:0] syn_raw;

   assign syn_raw = code_a_i ^ code_b_i;

   generate
      if (SYN_REG) begin : g_reg
         logic              vld_q;
         logic [CODE_W-1:0] syn_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               syn_q <= '0;
            end else begin
               vld_q <= start_i;
               if (start_i) syn_q <= syn_raw;
            end
         end
         assign vld_o = vld_q;
         assign syn_o = syn_q;
      end else begin : g_comb
         assign vld_o = start_i;
         assign syn_o = syn_raw;
      end
   endgenerate

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
   import ecc_fix_pkg::*;
#(
   parameter int CODE_W = 24,
   parameter int IDX_W  = 9,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [CODE_W-1:0] syn_i,
   output logic              done_o,
   output fix_status_e       status_o,
   output logic [IDX_W-1:0]  byte_o,
   output logic [BIT_W-1:0]  bit_o
);

   localparam int PAIRS = CODE_W / 2;

   generate
      if (IDX_W + BIT_W != PAIRS) begin : g_bad_split
         $error("ecc_classify: IDX_W + BIT_W must equal CODE_W/2");
      end
   endgenerate

   logic [PAIRS-1:0] pair_split;
   logic [PAIRS-1:0] even_bits;

   generate
      for (genvar k = 0; k < PAIRS; k++) begin : g_pair
         assign pair_split[k] = syn_i[2*k+1] ^ syn_i[2*k];
         assign even_bits[k]  = syn_i[2*k];
      end
   endgenerate

   fix_status_e      status_n;
   logic [IDX_W-1:0] byte_n;
   logic [BIT_W-1:0] bit_n;

   always_comb begin
      byte_n = '0;
      bit_n  = '0;
      if (syn_i == '0) begin
         status_n = ST_CLEAN;
      end else if (&pair_split) begin
         status_n = ST_DATA_FIXED;
         byte_n   = even_bits[IDX_W-1:0];
         bit_n    = even_bits[IDX_W +: BIT_W];
      end else if ($onehot(syn_i)) begin
         status_n = ST_CODE_BAD;
      end else begin
         status_n = ST_UNCORR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         status_o <= ST_CLEAN;
         byte_o   <= '0;
         bit_o    <= '0;
      end else begin
         done_o <= vld_i;
         if (vld_i) begin
            status_o <= status_n;
            byte_o   <= byte_n;
            bit_o    <= bit_n;
         end
      end
   end

   AST_CLEAN_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == ST_CLEAN) |-> ($past(syn_i) == '0)); // R1

   AST_LOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != ST_DATA_FIXED) |-> (byte_o == '0 && bit_o == '0)); // R6

   AST_CODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == ST_CODE_BAD) |-> ($countones($past(syn_i)) == 1)); // R5

endmodule

// File: rtl/ecc_rmw.sv
module ecc_rmw
   import ecc_fix_pkg::*;
#(
   parameter int IDX_W  = 9,
   parameter int BIT_W  = 3,
   parameter int DATA_W = 8,
   parameter bit FIX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  fix_status_e       status_i,
   input  logic [IDX_W-1:0]  byte_i,
   input  logic [BIT_W-1:0]  bit_i,
   output logic              buf_rd_o,
   output logic [IDX_W-1:0]  buf_raddr_o,
   input  logic [DATA_W-1:0] buf_rdata_i,
   output logic              buf_wr_o,
   output logic [IDX_W-1:0]  buf_waddr_o,
   output logic [DATA_W-1:0] buf_wdata_o
);

   generate
      if (DATA_W != (1 << BIT_W)) begin : g_bad_width
         $error("ecc_rmw: DATA_W must equal 2**BIT_W");
      end
   endgenerate

   generate
      if (FIX_EN) begin : g_fix
         logic              wr_q;
         logic [IDX_W-1:0]  waddr_q;
         logic [DATA_W-1:0] mask_q;

         assign buf_rd_o    = done_i && (status_i == ST_DATA_FIXED);
         assign buf_raddr_o = byte_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q    <= 1'b0;
               waddr_q <= '0;
               mask_q  <= '0;
            end else begin
               wr_q <= buf_rd_o;
               if (buf_rd_o) begin
                  waddr_q <= byte_i;
                  mask_q  <= DATA_W'(1) << bit_i;
               end
            end
         end

         assign buf_wr_o    = wr_q;
         assign buf_waddr_o = waddr_q;
         assign buf_wdata_o = buf_rdata_i ^ mask_q;

         AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            buf_wr_o |-> ($countones(buf_wdata_o ^ buf_rdata_i) == 1)); // R8

         AST_WADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            buf_wr_o |-> (buf_waddr_o == $past(buf_raddr_o))); // R8
      end else begin : g_nofix
         assign buf_rd_o    = 1'b0;
         assign buf_raddr_o = '0;
         assign buf_wr_o    = 1'b0;
         assign buf_waddr_o = '0;
         assign buf_wdata_o = '0;
      end
   endgenerate

endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
   import ecc_fix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   parameter int CODE_W       = 24,
   parameter bit SYN_REG      = 1'b1,
   parameter bit FIX_EN       = 1'b1,
   localparam int IDX_W       = $clog2(SECTOR_BYTES),
   localparam int BIT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_stored_i,
   input  logic [CODE_W-1:0] code_calc_i,
   output logic              done_o,
   output logic [1:0]        status_o,
   output logic [IDX_W-1:0]  err_byte_o,
   output logic [BIT_W-1:0]  err_bit_o,
   output logic              buf_rd_o,
   output logic [IDX_W-1:0]  buf_raddr_o,
   input  logic [DATA_W-1:0] buf_rdata_i,
   output logic              buf_wr_o,
   output logic [IDX_W-1:0]  buf_waddr_o,
   output logic [DATA_W-1:0] buf_wdata_o
);

   localparam int LAT = 1 + int'(SYN_REG);

   generate
      if ((1 << IDX_W) != SECTOR_BYTES) begin : g_bad_sector
         $error("ecc_syndrome_fixer: SECTOR_BYTES must be a power of two");
      end
      if (CODE_W != 2 * (IDX_W + BIT_W)) begin : g_bad_code
         $error("ecc_syndrome_fixer: CODE_W must be twice the location width");
      end
   endgenerate

   logic              syn_vld;
   logic [CODE_W-1:0] syn;
   fix_status_e       status_e;

   ecc_syn_stage #(.CODE_W(CODE_W), .SYN_REG(SYN_REG)) u_syn (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .code_a_i(code_stored_i),
      .code_b_i(code_calc_i),
      .vld_o   (syn_vld),
      .syn_o   (syn)
   );

   ecc_classify #(.CODE_W(CODE_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_cls (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (syn_vld),
      .syn_i   (syn),
      .done_o  (done_o),
      .status_o(status_e),
      .byte_o  (err_byte_o),
      .bit_o   (err_bit_o)
   );

   assign status_o = status_e;

   ecc_rmw #(.IDX_W(IDX_W), .BIT_W(BIT_W), .DATA_W(DATA_W), .FIX_EN(FIX_EN)) u_rmw (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done_o),
      .status_i   (status_e),
      .byte_i     (err_byte_o),
      .bit_i      (err_bit_o),
      .buf_rd_o   (buf_rd_o),
      .buf_raddr_o(buf_raddr_o),
      .buf_rdata_i(buf_rdata_i),
      .buf_wr_o   (buf_wr_o),
      .buf_waddr_o(buf_waddr_o),
      .buf_wdata_o(buf_wdata_o)
   );

   // cycles since reset, saturating, so latency checks never look before reset
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(age_q) >= LAT) |-> (done_o == $past(start_i, LAT))); // R7

   AST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_e != ST_DATA_FIXED) |=> !buf_wr_o); // R5

   AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_o |-> $past(buf_rd_o)); // R8

endmodule

// File: tb/sim_ecc_syndrome_fixer.sv
module sim_ecc_syndrome_fixer;

   localparam int NB = 512;

   typedef struct {
      logic [1:0] st;
      logic [8:0] by;
      logic [2:0] bi;
      int         cyc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] stored = '0;
   logic [23:0] calc = '0;

   logic        done0, rd0, wr0, done1, rd1, wr1;
   logic [1:0]  st0, st1;
   logic [8:0]  by0, by1, ra0, wa0, ra1, wa1;
   logic [2:0]  bi0, bi1;
   logic [7:0]  rdata0, wd0, wd1;

   logic [7:0]  mem [NB];
   logic [7:0]  exp_mem [NB];

   exp_t q0[$];
   exp_t q1[$];

   int cyc = 0;
   int nchk = 0;
   int nfail = 0;
   int nfix = 0;
   int wr_seen = 0;
   int u1_strobes = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ecc_syndrome_fixer u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .code_stored_i(stored), .code_calc_i(calc),
      .done_o(done0), .status_o(st0), .err_byte_o(by0), .err_bit_o(bi0),
      .buf_rd_o(rd0), .buf_raddr_o(ra0), .buf_rdata_i(rdata0),
      .buf_wr_o(wr0), .buf_waddr_o(wa0), .buf_wdata_o(wd0)
   );

   ecc_syndrome_fixer #(.SYN_REG(1'b0), .FIX_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .code_stored_i(stored), .code_calc_i(calc),
      .done_o(done1), .status_o(st1), .err_byte_o(by1), .err_bit_o(bi1),
      .buf_rd_o(rd1), .buf_raddr_o(ra1), .buf_rdata_i(8'h00),
      .buf_wr_o(wr1), .buf_waddr_o(wa1), .buf_wdata_o(wd1)
   );

   // sector buffer model: one-cycle read latency, independent write port
   always @(posedge clk) begin
      if (wr0) mem[wa0] <= wd0;
      if (rd0) rdata0 <= mem[ra0];
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic string tag_of(input logic [1:0] s);
      case (s)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   // syndrome for a single data-bit error: even bits carry {bit,byte}, odd bits their inverse
   function automatic logic [23:0] fix_diff(input logic [8:0] by, input logic [2:0] bi);
      logic [11:0] e;
      logic [23:0] d;
      e = {bi, by};
      for (int k = 0; k < 12; k++) begin
         d[2*k]   = e[k];
         d[2*k+1] = ~e[k];
      end
      return d;
   endfunction

   // monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr0) wr_seen++;
         if (rd1 || wr1) u1_strobes++;
         if (done0) begin
            if (q0.size() == 0) check(1'b0, "R7", "u0 done without start", 1, 0);
            else begin
               exp_t e;
               e = q0.pop_front();
               check(st0 == e.st, tag_of(e.st), "u0 status", st0, e.st);
               check(by0 == e.by, "R4", "u0 byte index", by0, e.by);
               check(bi0 == e.bi, "R3", "u0 bit index", bi0, e.bi);
               check(cyc == e.cyc + 2, "R7", "u0 latency", cyc - e.cyc, 2);
            end
         end
         if (done1) begin
            if (q1.size() == 0) check(1'b0, "R7", "u1 done without start", 1, 0);
            else begin
               exp_t e;
               e = q1.pop_front();
               check(st1 == e.st, tag_of(e.st), "u1 status", st1, e.st);
               check(by1 == e.by && bi1 == e.bi, "R10", "u1 location", {by1, bi1}, {e.by, e.bi});
               check(cyc == e.cyc + 1, "R7", "u1 latency", cyc - e.cyc, 1);
            end
         end
      end
   end

   task automatic send(input logic [23:0] c, input logic [23:0] diff,
                       input logic [1:0] st, input logic [8:0] by, input logic [2:0] bi);
      exp_t e;
      @(negedge clk);
      start  = 1'b1;
      calc   = c;
      stored = c ^ diff;
      e.st = st; e.by = by; e.bi = bi; e.cyc = cyc;
      q0.push_back(e);
      q1.push_back(e);
      if (st == 2'd1) begin
         exp_mem[by] = exp_mem[by] ^ (8'd1 << bi);
         nfix++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   initial begin
      for (int i = 0; i < NB; i++) begin
         mem[i]     = 8'(i * 7 + 3);
         exp_mem[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done0 == 0 && rd0 == 0 && wr0 == 0 && st0 == 0, "R9", "reset state",
            {done0, rd0, wr0, st0}, 0);

      send(24'h5A3C96, 24'h000000, 2'd0, 9'd0, 3'd0);               // R1
      idle(2);
      send(24'h123456, fix_diff(9'd0, 3'd0), 2'd1, 9'd0, 3'd0);     // R2 low corner
      idle(3);
      send(24'hABCDEF, fix_diff(9'd511, 3'd7), 2'd1, 9'd511, 3'd7); // R3 R4 high corner
      idle(3);
      send(24'h0F0F0F, fix_diff(9'h155, 3'd5), 2'd1, 9'h155, 3'd5);
      idle(3);
      send(24'hFFFFFF, fix_diff(9'h0AA, 3'd2), 2'd1, 9'h0AA, 3'd2);
      idle(3);
      send(24'h777777, 24'h000001, 2'd2, 9'd0, 3'd0);               // R5
      idle(2);
      send(24'h000000, 24'h800000, 2'd2, 9'd0, 3'd0);
      idle(2);
      send(24'h13579B, 24'h001000, 2'd2, 9'd0, 3'd0);
      idle(2);
      send(24'h246801, 24'h000003, 2'd3, 9'd0, 3'd0);               // R6
      idle(2);
      send(24'h246801, 24'hFFFFFF, 2'd3, 9'd0, 3'd0);
      idle(2);
      send(24'h9ABCDE, fix_diff(9'd5, 3'd3) ^ 24'h000002, 2'd3, 9'd0, 3'd0);
      idle(2);

      // back-to-back starts overlapping the repair traffic
      send(24'h111111, fix_diff(9'd17, 3'd1), 2'd1, 9'd17, 3'd1);
      send(24'h222222, fix_diff(9'd300, 3'd6), 2'd1, 9'd300, 3'd6);
      send(24'h333333, 24'h000000, 2'd0, 9'd0, 3'd0);
      send(24'h444444, 24'h000200, 2'd2, 9'd0, 3'd0);
      send(24'h555555, fix_diff(9'd42, 3'd4), 2'd1, 9'd42, 3'd4);
      idle(4);

      for (int i = 0; i < 20; i++) begin
         logic [8:0] by;
         logic [2:0] bi;
         by = 9'((i * 37 + 11) % NB);
         bi = 3'(i % 8);
         send(24'(i * 12345 + 7), fix_diff(by, bi), 2'd1, by, bi);
         idle(1);
      end
      idle(6);

      begin
         int bad;
         bad = 0;
         for (int i = 0; i < NB; i++) if (mem[i] !== exp_mem[i]) bad++;
         check(bad == 0, "R8", "sector bytes differing from model", bad, 0);
      end
      check(wr_seen == nfix, "R8", "buffer writes vs fixed results", wr_seen, nfix);
      check(u1_strobes == 0, "R10", "buffer strobes with repair disabled", u1_strobes, 0);
      check(q0.size() == 0 && q1.size() == 0, "R7", "results outstanding", q0.size() + q1.size(), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule